// File: doc/BRIEF.md
# Program Sequencer with Stack Pointer

This block handles program flow for a single-accumulator processor. It holds the program counter and a stack pointer into data memory. For each instruction it takes a decoded instruction class, the instruction operand, four condition flags and the accumulator value. From these it works out the next program counter and drives the data-memory address. For stack pushes and pops it also raises a write or read strobe. The instruction word upstream is an 8-bit opcode, whose top three bits are reserved, followed by an operand of up to 32 bits. Decoding that opcode into a class happens outside this block.

Instructions enter through a valid/ready handshake. An instruction is accepted in a cycle where `instr_valid` and `instr_ready` are both high, and it completes in that same cycle. The producer may hold `instr_valid` low for any number of cycles. While valid is low, neither the PC nor the SP moves and no strobe fires. `instr_ready` is high from reset until a HALT is accepted. After that it stays low until the next reset, so the instruction on offer is held and never consumed. The current PC is always available on `save_pc`, zero-extended, so the datapath can copy it into the accumulator.

Subroutine call and return need no dedicated hardware. They are sequences of save-PC, push, jump, pop, add and load-PC.

Top module: `prog_seq`

## Requirements
- R1: During and after reset, `pc` and `sp` are 0, `halted` is 0 and `instr_ready` is 1.
- R2: An accepted instruction of class ordinary (0), memory (1) or any unassigned code (12 to 15) sets `pc` to `pc+1`. With no acceptance, `pc` and `sp` keep their values and both strobes stay low.
- R3: An accepted unconditional jump (class 2) loads the low PCW bits of `operand` into `pc`.
- R4: Conditional jumps use these classes and flags: class 3 tests `flag_z`, class 4 tests `flag_ov`, class 5 tests `flag_c`, class 6 tests `flag_eq`. If the tested flag is 1, `pc` takes the operand. Otherwise `pc` advances by one. The other flags have no effect.
- R5: An accepted relative jump (class 7) sets `pc` to `pc + operand`, wrapping modulo 2^PCW.
- R6: An accepted load-PC (class 8) loads the low PCW bits of `acc` into `pc`. `save_pc` always shows the current `pc`, zero-extended.
- R7: A push (class 9) drives `dmem_addr = sp` and, when accepted, raises `dmem_we` for that cycle. `sp` then becomes `sp+1`, wrapping modulo 2^AW.
- R8: A pop (class 10) drives `dmem_addr = sp-1` and, when accepted, raises `dmem_re` for that cycle. `sp` then becomes `sp-1`, wrapping modulo 2^AW.
- R9: A memory-class instruction drives `dmem_addr` from the low AW bits of `operand` and raises no strobe. All other classes drive address 0. The strobes never rise together.
- R10: An accepted HALT (class 11) keeps `pc` unchanged and sets `halted`. From then until reset, `instr_ready` is 0 and `pc`, `sp` and the strobes stay unchanged, whatever is offered.
- R11: `next_pc` always shows the value `pc` would take if the offered instruction were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | Sequencer accepts the offered instruction |
| op_class | input | 4 | Decoded instruction class |
| operand | input | OPW (32) | Instruction operand |
| flag_z | input | 1 | Zero flag |
| flag_ov | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_eq | input | 1 | Equal flag |
| acc | input | DW (16) | Accumulator value |
| pc | output | PCW (16) | Program counter |
| next_pc | output | PCW (16) | PC after acceptance of the offered instruction |
| save_pc | output | DW (16) | Current PC, zero-extended, for save-PC |
| sp | output | AW (8) | Stack pointer |
| dmem_addr | output | AW (8) | Data-memory address |
| dmem_we | output | 1 | Stack write strobe (push) |
| dmem_re | output | 1 | Stack read strobe (pop) |
| halted | output | 1 | HALT has been accepted |

## Verification
Two cases put two functions in one cycle. In the first, a stack operation is offered while the handshake stalls. The bench offers a push with `instr_valid` low and then offers more instructions after HALT, and expects no strobe and no move in either register. In the second, a program-flow change lands on a stack boundary. A pop from an empty stack must address the top location and wrap the SP, and a relative jump must wrap the PC in the same run as the call/return idiom. A scoreboard model predicts `pc`, `sp` and `halted` for every cycle, and compares the combinational address and strobes in the same cycle the instruction is offered.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam int CLW   = 4;
  localparam int NCOND = 4;

  typedef enum logic [CLW-1:0] {
    CL_SEQ  = 4'd0,
    CL_MEM  = 4'd1,
    CL_JMP  = 4'd2,
    CL_JZ   = 4'd3,
    CL_JOV  = 4'd4,
    CL_JC   = 4'd5,
    CL_JEQ  = 4'd6,
    CL_JREL = 4'd7,
    CL_LDPC = 4'd8,
    CL_PUSH = 4'd9,
    CL_POP  = 4'd10,
    CL_HALT = 4'd11
  } op_class_e;
endpackage

// File: rtl/prog_seq_issue.sv
module prog_seq_issue
  import prog_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic [CLW-1:0] cls,
  output logic           ready,
  output logic           fire,
  output logic           halted
);
  logic halt_q;

  assign ready  = !halt_q;
  assign fire   = valid && ready;
  assign halted = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      halt_q <= 1'b0;
    else if (fire && cls == CL_HALT)
      halt_q <= 1'b1;
  end
endmodule

// File: rtl/prog_seq_pc.sv
module prog_seq_pc
  import prog_seq_pkg::*;
#(
  parameter int PCW = 16,
  parameter int DW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CLW-1:0]   cls,
  input  logic [PCW-1:0]   target,
  input  logic [NCOND-1:0] flags,
  input  logic [DW-1:0]    acc,
  output logic [PCW-1:0]   pc,
  output logic [PCW-1:0]   next_pc
);
  logic [PCW-1:0]   pc_q;
  logic [PCW-1:0]   pc_inc;
  logic [PCW-1:0]   pc_rel;
  logic [NCOND-1:0] cond_hit;
  logic             is_cond;

  assign pc_inc = pc_q + PCW'(1);
  assign pc_rel = pc_q + target;

  // one comparator per flag; class codes of the conditional jumps are consecutive
  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    localparam logic [CLW-1:0] CODE = CLW'(int'(CL_JZ) + i);
    assign cond_hit[i] = (cls == CODE) && flags[i];
  end

  assign is_cond = (cls >= CL_JZ) && (cls <= CL_JEQ);

  always_comb begin
    next_pc = pc_inc;
    if (is_cond) begin
      next_pc = (|cond_hit) ? target : pc_inc;
    end else begin
      case (cls)
        CL_JMP:  next_pc = target;
        CL_JREL: next_pc = pc_rel;
        CL_LDPC: next_pc = PCW'(acc);
        CL_HALT: next_pc = pc_q;
        default: next_pc = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= '0;
    else if (fire)
      pc_q <= next_pc;
  end

  assign pc = pc_q;
endmodule

// File: rtl/prog_seq_stack.sv
module prog_seq_stack
  import prog_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [CLW-1:0] cls,
  input  logic [AW-1:0]  mem_ptr,
  output logic [AW-1:0]  sp,
  output logic [AW-1:0]  addr,
  output logic           we,
  output logic           re
);
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_dn;
  logic          is_push;
  logic          is_pop;

  assign sp_dn   = sp_q - AW'(1);
  assign is_push = (cls == CL_PUSH);
  assign is_pop  = (cls == CL_POP);

  always_comb begin
    addr = '0;
    if (is_push)            addr = sp_q;
    else if (is_pop)        addr = sp_dn;
    else if (cls == CL_MEM) addr = mem_ptr;
  end

  assign we = fire && is_push;
  assign re = fire && is_pop;

  always_ff @(posedge clk) begin
    if (!rst_n)  sp_q <= '0;
    else if (we) sp_q <= sp_q + AW'(1);
    else if (re) sp_q <= sp_dn;
  end

  assign sp = sp_q;
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int PCW = 16,
  parameter int OPW = 32,
  parameter int DW  = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  output logic           instr_ready,
  input  logic [3:0]     op_class,
  input  logic [OPW-1:0] operand,
  input  logic           flag_z,
  input  logic           flag_ov,
  input  logic           flag_c,
  input  logic           flag_eq,
  input  logic [DW-1:0]  acc,
  output logic [PCW-1:0] pc,
  output logic [PCW-1:0] next_pc,
  output logic [DW-1:0]  save_pc,
  output logic [AW-1:0]  sp,
  output logic [AW-1:0]  dmem_addr,
  output logic           dmem_we,
  output logic           dmem_re,
  output logic           halted
);
  logic             fire;
  logic [NCOND-1:0] flags;

  // bit order follows the class order of the conditional jumps
  assign flags = {flag_eq, flag_c, flag_ov, flag_z};

  prog_seq_issue u_issue (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (instr_valid),
    .cls    (op_class),
    .ready  (instr_ready),
    .fire   (fire),
    .halted (halted)
  );

  prog_seq_pc #(.PCW(PCW), .DW(DW)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .cls     (op_class),
    .target  (PCW'(operand)),
    .flags   (flags),
    .acc     (acc),
    .pc      (pc),
    .next_pc (next_pc)
  );

  prog_seq_stack #(.AW(AW)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .cls     (op_class),
    .mem_ptr (AW'(operand)),
    .sp      (sp),
    .addr    (dmem_addr),
    .we      (dmem_we),
    .re      (dmem_re)
  );

  assign save_pc = DW'(pc);
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
  parameter int PCW = 16,
  parameter int OPW = 32,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_valid,
  input logic           instr_ready,
  input logic [3:0]     op_class,
  input logic [OPW-1:0] operand,
  input logic [PCW-1:0] pc,
  input logic [AW-1:0]  sp,
  input logic [AW-1:0]  dmem_addr,
  input logic           dmem_we,
  input logic           dmem_re,
  input logic           halted
);
  logic fire;
  assign fire = instr_valid && instr_ready;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && sp == '0 && !halted));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(pc) && $stable(sp)));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_class == 4'd0) |=> pc == PCW'($past(pc) + PCW'(1)));

  p_jump_abs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_class == 4'd2) |=> pc == PCW'($past(operand)));

  p_push_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> sp == AW'($past(sp) + AW'(1)));

  p_push_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> dmem_addr == sp);

  p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> sp == AW'($past(sp) - AW'(1)));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dmem_we, dmem_re}));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !instr_ready && $stable(pc)));
endmodule

bind prog_seq prog_seq_checker #(.PCW(PCW), .OPW(OPW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .op_class    (op_class),
  .operand     (operand),
  .pc          (pc),
  .sp          (sp),
  .dmem_addr   (dmem_addr),
  .dmem_we     (dmem_we),
  .dmem_re     (dmem_re),
  .halted      (halted)
);

// File: tb/sim_prog_seq.sv
`timescale 1ns/1ps
module sim_prog_seq;
  localparam int PCW = 16, OPW = 32, DW = 16, AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [3:0] op_class = '0;
  logic [OPW-1:0] operand = '0;
  logic flag_z = 0, flag_ov = 0, flag_c = 0, flag_eq = 0;
  logic [DW-1:0] acc = '0;
  logic instr_ready, dmem_we, dmem_re, halted;
  logic [PCW-1:0] pc, next_pc;
  logic [DW-1:0] save_pc;
  logic [AW-1:0] sp, dmem_addr;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [PCW-1:0] pc; logic [AW-1:0] sp; logic halt; } exp_t;
  exp_t exp_q[$];

  logic [PCW-1:0] m_pc = '0;
  logic [AW-1:0]  m_sp = '0;
  logic           m_halt = 1'b0;

  always #10 clk = ~clk;

  prog_seq #(.PCW(PCW), .OPW(OPW), .DW(DW), .AW(AW)) u0 (.*);

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: offers one instruction for one cycle and queues the predicted state
  task automatic step(input logic v, input logic [3:0] c, input logic [OPW-1:0] op,
                      input logic [3:0] f, input logic [DW-1:0] a);
    logic fire;
    logic [PCW-1:0] npc;
    logic [AW-1:0] eaddr;
    logic taken;
    exp_t e;
    @(negedge clk);
    instr_valid = v; op_class = c; operand = op; acc = a;
    flag_z = f[0]; flag_ov = f[1]; flag_c = f[2]; flag_eq = f[3];
    #1;
    fire = v && !m_halt;
    eaddr = (c == 4'd9) ? m_sp : (c == 4'd10) ? m_sp - AW'(1) :
            (c == 4'd1) ? op[AW-1:0] : '0;
    taken = (c >= 4'd3 && c <= 4'd6) && f[c - 4'd3];
    case (c)
      4'd2:               npc = op[PCW-1:0];
      4'd3, 4'd4, 4'd5, 4'd6: npc = taken ? op[PCW-1:0] : m_pc + 1'b1;
      4'd7:               npc = m_pc + op[PCW-1:0];
      4'd8:               npc = a[PCW-1:0];
      4'd11:              npc = m_pc;
      default:            npc = m_pc + 1'b1;
    endcase
    check(dmem_addr == eaddr, "R9 addr (R7/R8)", dmem_addr, eaddr);
    check(dmem_we == (fire && c == 4'd9), "R7 we", dmem_we, fire && c == 4'd9);
    check(dmem_re == (fire && c == 4'd10), "R8 re", dmem_re, fire && c == 4'd10);
    check(instr_ready == !m_halt, "R10 ready", instr_ready, !m_halt);
    check(save_pc == DW'(m_pc), "R6 save_pc", save_pc, m_pc);
    if (!m_halt) check(next_pc == npc, "R11 next_pc", next_pc, npc);
    if (fire) begin
      m_pc = npc;
      if (c == 4'd9) m_sp = m_sp + 1'b1;
      if (c == 4'd10) m_sp = m_sp - 1'b1;
      if (c == 4'd11) m_halt = 1'b1;
    end
    e.pc = m_pc; e.sp = m_sp; e.halt = m_halt;
    exp_q.push_back(e);
  endtask

  // monitor: compares registered state shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(pc == e.pc, "R2-R5 pc", pc, e.pc);
        check(sp == e.sp, "R7 R8 sp", sp, e.sp);
        check(halted == e.halt, "R10 halted", halted, e.halt);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; instr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    m_pc = '0; m_sp = '0; m_halt = 1'b0;
    check(pc == '0 && sp == '0, "R1 regs", {pc, sp}, 0);
    check(!halted && instr_ready, "R1 ready", {halted, instr_ready}, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PCW-1:0] ret;
    do_reset();
    // R2 ordinary advance and idle hold with a push offered but not valid
    step(1, 4'd0, 0, 0, 0);
    step(1, 4'd0, 0, 0, 0);
    step(0, 4'd9, 0, 0, 0);
    // R9 memory class
    step(1, 4'd1, 32'h1234_00A5, 0, 0);
    // R3 absolute jump
    step(1, 4'd2, 32'h0001_0040, 4'hF, 0);
    // R4 conditional jumps, taken and not
    step(1, 4'd3, 32'h100, 4'b1110, 0);
    step(1, 4'd3, 32'h100, 4'b0001, 0);
    step(1, 4'd4, 32'h180, 4'b0010, 0);
    step(1, 4'd5, 32'h300, 4'b1011, 0);
    step(1, 4'd5, 32'h300, 4'b0100, 0);
    step(1, 4'd6, 32'h340, 4'b0111, 0);
    step(1, 4'd6, 32'hFFF8, 4'b1000, 0);
    // R5 relative jump wrapping forward then backward
    step(1, 4'd7, 32'h0000_0010, 0, 0);
    step(1, 4'd7, 32'hFFFF_FFF0, 0, 0);
    // R7 R8 stack, including pop on empty stack (wrap)
    step(1, 4'd9, 0, 0, 0);
    step(1, 4'd9, 0, 0, 0);
    step(1, 4'd10, 0, 0, 0);
    step(1, 4'd10, 0, 0, 0);
    step(1, 4'd10, 0, 0, 0);
    step(1, 4'd9, 0, 0, 0);
    // call/return idiom: save, push, jump, pop, add, load-PC (R6)
    ret = m_pc;
    step(1, 4'd0, 0, 0, 0);
    step(1, 4'd9, 0, 0, DW'(ret));
    step(1, 4'd2, 32'h200, 0, 0);
    step(1, 4'd0, 0, 0, 0);
    step(1, 4'd10, 0, 0, 0);
    step(1, 4'd0, 0, 0, 0);
    step(1, 4'd8, 0, 0, DW'(ret + 16'd4));
    step(1, 4'd8, 0, 0, 16'hBEEF);
    // R2 unassigned class codes
    step(1, 4'd13, 0, 0, 0);
    step(1, 4'd15, 0, 0, 0);
    // R10 halt and offers afterwards
    step(1, 4'd11, 0, 0, 0);
    step(1, 4'd9, 0, 0, 0);
    step(1, 4'd2, 32'h55, 4'hF, 0);
    step(0, 4'd0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #5;
    // R1 reset leaves halt
    do_reset();
    step(1, 4'd0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule